// File: doc/BRIEF.md
# Corner-Turn Source Arbiter

This block decides which of N processing nodes may use a shared redistribution path during a distributed matrix transpose. Each node is both a source and a destination. A source raises its request line when its outgoing buffer holds the pieces it must scatter. The arbiter then lets one source at a time sweep the path. That source delivers one sub-block to every node in ascending node order, itself included. A delivery goes ahead only while the addressed node says it has a free incoming buffer.

Sources are ordered by the cycle in which their request was first seen. When several requests first appear in the same cycle, a rotating starting point decides the order among them, and that starting point moves on by one node after each such tie. A corner turn opens on a start pulse and closes on its own once every node has finished its sweep. The arbiter pulses a completion strobe at that point. The data words themselves and the buffer addressing are handled elsewhere. This block only produces the source index, the destination index and a strobe that marks a beat.

Top module: `ct_src_arbiter`

## Requirements
- R1: After reset, xfer_valid, src_done and ct_done are all low, and no corner turn is open.
- R2: A source whose request is captured in an earlier cycle completes its whole sweep before any source captured in a later cycle begins.
- R3: Requests first captured in the same cycle are served in rotating order, beginning at a pointer node and counting upward with wrap to node 0. The pointer is node 0 after reset. It advances by one node after every cycle in which two or more requests are captured, and it stays put after a cycle with only one capture.
- R4: A granted source issues exactly N beats, with xfer_dst taking the values 0, 1, …, N-1 in that order. The beat where xfer_dst equals xfer_src is included.
- R5: xfer_valid is high only while dst_rdy[xfer_dst] is high. While the addressed destination is not ready, the arbiter waits on that same destination.
- R6: xfer_src stays constant from the first to the last beat of a sweep.
- R7: In the cycle after the last beat of a sweep, src_done pulses for one cycle. Only the bit of the finished source is set.
- R8: ct_done pulses for one cycle, and only once per corner turn, in the cycle after the last beat of the N-th completed sweep. This is the same cycle as that sweep's src_done pulse.
- R9: A request is ignored while no corner turn is open. A request from a source that has already been captured in the current corner turn is also ignored, until the next accepted start pulse.
- R10: A ct_start pulse that arrives while a corner turn is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ct_start | input | 1 | One-cycle pulse that opens a corner turn |
| src_req | input | N_NODES | Per-source request: outgoing buffer ready |
| dst_rdy | input | N_NODES | Per-destination free incoming buffer |
| xfer_valid | output | 1 | A sub-block beat moves this cycle |
| xfer_src | output | $clog2(N_NODES) | Index of the source currently granted |
| xfer_dst | output | $clog2(N_NODES) | Index of the destination currently addressed |
| src_done | output | N_NODES | One-cycle per-source sweep-complete pulse |
| ct_done | output | 1 | One-cycle corner-turn-complete pulse |

## Verification
The hardest case to reach is a tie that is resolved from a pointer other than node 0. The rotating pointer cannot be seen at the ports, and only a tie cycle moves it. The stimulus therefore runs several corner turns back to back: a tie mixed with single arrivals, then two full four-way ties, then a single arrival followed by a two-way tie. Each expected order follows from the pointer position that the earlier turns imply. Throughout, requests stay asserted, and a start pulse is thrown in mid-turn. If the design accepted either of these, the extra beats would show up at the scoreboard.

// File: rtl/ct_pkg.sv
package ct_pkg;
  // Modular increment for node indices when the node count need not be a power of two.
  function automatic int unsigned wrap_add(int unsigned base, int unsigned step, int unsigned n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/ct_arrival.sv
module ct_arrival #(
  parameter int N_NODES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clear_i,
  input  logic                            open_i,
  input  logic [N_NODES-1:0]              src_req_i,
  output logic [$clog2(N_NODES+1)-1:0]    push_cnt_o,
  output logic [N_NODES-1:0][((N_NODES>1)?$clog2(N_NODES):1)-1:0] push_ids_o
);
  import ct_pkg::*;
  localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam int CW = $clog2(N_NODES + 1);

  logic [N_NODES-1:0] taken_q, taken_d, fresh;
  logic [IW-1:0]      rot_q, rot_d;
  logic [CW-1:0]      cnt;

  // Scan sources from the rotation pointer upward; the scan order is the tie order.
  always_comb begin
    fresh      = '0;
    push_ids_o = '0;
    cnt        = '0;
    for (int k = 0; k < N_NODES; k++) begin
      if (open_i && src_req_i[IW'(wrap_add(int'(rot_q), k, N_NODES))]
          && !taken_q[IW'(wrap_add(int'(rot_q), k, N_NODES))]) begin
        fresh[IW'(wrap_add(int'(rot_q), k, N_NODES))] = 1'b1;
        push_ids_o[cnt[IW-1:0]] = IW'(wrap_add(int'(rot_q), k, N_NODES));
        cnt = cnt + CW'(1);
      end
    end
    push_cnt_o = cnt;
    taken_d    = clear_i ? '0 : (taken_q | fresh);
    rot_d      = (cnt > CW'(1)) ? IW'(wrap_add(int'(rot_q), 1, N_NODES)) : rot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= '0;
      rot_q   <= '0;
    end else begin
      taken_q <= taken_d;
      rot_q   <= rot_d;
    end
  end
endmodule

// File: rtl/ct_order_fifo.sv
module ct_order_fifo #(
  parameter int N_NODES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [$clog2(N_NODES+1)-1:0]    push_cnt_i,
  input  logic [N_NODES-1:0][((N_NODES>1)?$clog2(N_NODES):1)-1:0] push_ids_i,
  input  logic                            pop_i,
  output logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] head_o,
  output logic                            empty_o
);
  import ct_pkg::*;
  localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam int CW = $clog2(N_NODES + 1);

  logic [N_NODES-1:0][IW-1:0] mem_q, mem_d;
  logic [IW-1:0]              rd_q, rd_d;
  logic [CW-1:0]              cnt_q, cnt_d;

  // Several entries may land in one cycle; they fill consecutive slots after the tail.
  always_comb begin
    mem_d = mem_q;
    for (int k = 0; k < N_NODES; k++) begin
      if (CW'(k) < push_cnt_i)
        mem_d[IW'(wrap_add(int'(rd_q), int'(cnt_q) + k, N_NODES))] = push_ids_i[k];
    end
    rd_d  = pop_i ? IW'(wrap_add(int'(rd_q), 1, N_NODES)) : rd_q;
    cnt_d = cnt_q + push_cnt_i - (pop_i ? CW'(1) : CW'(0));
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ct_sweep_engine.sv
module ct_sweep_engine #(
  parameter int N_NODES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 empty_i,
  input  logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] head_i,
  input  logic [N_NODES-1:0]   dst_rdy_i,
  output logic                 pop_o,
  output logic                 beat_o,
  output logic                 sweep_end_o,
  output logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] src_o,
  output logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] dst_o
);
  localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam logic [IW-1:0] LAST_DST = IW'(N_NODES - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] src_q, src_d, dst_q, dst_d;

  assign pop_o       = !busy_q && !empty_i;
  assign beat_o      = busy_q && dst_rdy_i[dst_q];
  assign sweep_end_o = beat_o && (dst_q == LAST_DST);
  assign src_o       = src_q;
  assign dst_o       = dst_q;

  always_comb begin
    busy_d = busy_q;
    src_d  = src_q;
    dst_d  = dst_q;
    if (pop_o) begin
      busy_d = 1'b1;
      src_d  = head_i;
      dst_d  = '0;
    end else if (beat_o) begin
      if (dst_q == LAST_DST) begin
        busy_d = 1'b0;
        dst_d  = '0;
      end else begin
        dst_d  = dst_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      busy_q <= busy_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
    end
  end
endmodule

// File: rtl/ct_src_arbiter.sv
module ct_src_arbiter #(
  parameter int N_NODES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ct_start,
  input  logic [N_NODES-1:0]   src_req,
  input  logic [N_NODES-1:0]   dst_rdy,
  output logic                 xfer_valid,
  output logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] xfer_src,
  output logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] xfer_dst,
  output logic [N_NODES-1:0]   src_done,
  output logic                 ct_done
);
  localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam int CW = $clog2(N_NODES + 1);

  logic                       open_q, open_d, start_ok;
  logic [CW-1:0]              fin_q, fin_d;
  logic [N_NODES-1:0]         sdone_q, sdone_d;
  logic                       cdone_q, cdone_d;
  logic [CW-1:0]              push_cnt;
  logic [N_NODES-1:0][IW-1:0] push_ids;
  logic                       pop, empty, sweep_end;
  logic [IW-1:0]              head;

  assign start_ok = ct_start && !open_q;

  ct_arrival #(.N_NODES(N_NODES)) u_arrival (
    .clk(clk), .rst_n(rst_n), .clear_i(start_ok), .open_i(open_q),
    .src_req_i(src_req), .push_cnt_o(push_cnt), .push_ids_o(push_ids)
  );

  ct_order_fifo #(.N_NODES(N_NODES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_cnt_i(push_cnt), .push_ids_i(push_ids),
    .pop_i(pop), .head_o(head), .empty_o(empty)
  );

  ct_sweep_engine #(.N_NODES(N_NODES)) u_engine (
    .clk(clk), .rst_n(rst_n), .empty_i(empty), .head_i(head), .dst_rdy_i(dst_rdy),
    .pop_o(pop), .beat_o(xfer_valid), .sweep_end_o(sweep_end),
    .src_o(xfer_src), .dst_o(xfer_dst)
  );

  always_comb begin
    open_d  = open_q;
    fin_d   = fin_q;
    sdone_d = '0;
    cdone_d = 1'b0;
    if (start_ok) begin
      open_d = 1'b1;
      fin_d  = '0;
    end
    if (sweep_end) begin
      sdone_d[xfer_src] = 1'b1;
      if (fin_q == CW'(N_NODES - 1)) begin
        fin_d   = '0;
        open_d  = 1'b0;
        cdone_d = 1'b1;
      end else begin
        fin_d   = fin_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      fin_q   <= '0;
      sdone_q <= '0;
      cdone_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      fin_q   <= fin_d;
      sdone_q <= sdone_d;
      cdone_q <= cdone_d;
    end
  end

  assign src_done = sdone_q;
  assign ct_done  = cdone_q;
endmodule

// File: rtl/ct_src_arbiter_chk.sv
module ct_src_arbiter_chk #(
  parameter int N_NODES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_NODES-1:0] dst_rdy,
  input logic               xfer_valid,
  input logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] xfer_src,
  input logic [((N_NODES>1)?$clog2(N_NODES):1)-1:0] xfer_dst,
  input logic [N_NODES-1:0] src_done,
  input logic               ct_done
);
  localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_NODES - 1);

  a_r5_valid_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> dst_rdy[xfer_dst]);

  a_r4_dst_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_dst != LAST) |=> (xfer_dst == $past(xfer_dst) + IW'(1)));

  a_r6_src_held: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_dst != LAST) |=> $stable(xfer_src));

  a_r7_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_done));

  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_dst == LAST) |=> (src_done != '0));

  a_r8_turn_end_with_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
    ct_done |-> ($countones(src_done) == 1));
endmodule

bind ct_src_arbiter ct_src_arbiter_chk #(.N_NODES(N_NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dst_rdy(dst_rdy), .xfer_valid(xfer_valid),
  .xfer_src(xfer_src), .xfer_dst(xfer_dst), .src_done(src_done), .ct_done(ct_done)
);

// File: tb/ct_src_arbiter_bench.sv
module ct_src_arbiter_bench;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, ct_start;
  logic [N-1:0]  src_req, dst_rdy, src_done;
  logic          xfer_valid, ct_done;
  logic [IW-1:0] xfer_src, xfer_dst;

  ct_src_arbiter #(.N_NODES(N)) u_ct_src_arbiter (
    .clk(clk), .rst_n(rst_n), .ct_start(ct_start), .src_req(src_req), .dst_rdy(dst_rdy),
    .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .src_done(src_done), .ct_done(ct_done)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  int ct_done_seen = 0;
  bit mon_en = 1'b0;
  bit rdy_random = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit pend_done = 1'b0;
  bit pend_last = 1'b0;
  int pend_src = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: one expected beat per destination, in order.
  task automatic expect_sweep(int s);
    for (int d = 0; d < N; d++) exp_q.push_back(s * N + d);
  endtask

  always @(posedge clk) begin
    #1;
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dst_rdy <= rdy_random ? lfsr[3:0] : '1;
  end

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (pend_done) begin
        chk(src_done == N'(1 << pend_src), "R7 src_done pulse", int'(src_done), 1 << pend_src);
        chk(ct_done == pend_last, "R8 ct_done timing", int'(ct_done), int'(pend_last));
      end else begin
        if (src_done != '0) chk(1'b0, "R7 stray src_done", int'(src_done), 0);
        if (ct_done) chk(1'b0, "R8 stray ct_done", 1, 0);
      end
      pend_done = 1'b0;
      if (xfer_valid) begin
        chk(dst_rdy[xfer_dst], "R5 beat without ready", int'(dst_rdy), 1 << xfer_dst);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 R10 unexpected beat", int'(xfer_src) * N + int'(xfer_dst), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(xfer_src) * N + int'(xfer_dst) == e, "R2 R3 R4 R6 beat order",
              int'(xfer_src) * N + int'(xfer_dst), e);
        end
        if (xfer_dst == IW'(N - 1)) begin
          pend_done = 1'b1;
          pend_src  = int'(xfer_src);
          pend_last = (exp_q.size() == 0);
        end
      end
      if (ct_done) ct_done_seen++;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 ct_start = 1'b1;
    @(posedge clk); #1 ct_start = 1'b0;
  endtask

  task automatic finish_turn(string tag);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (ct_done) got = 1'b1;
    end
    chk(got, {tag, " R8 turn completes"}, int'(got), 1);
    chk(exp_q.size() == 0, {tag, " R4 all beats seen"}, exp_q.size(), 0);
    @(posedge clk); #1 src_req = '0;
    repeat (4) @(negedge clk);
    chk(ct_done_seen == 1, {tag, " R8 single ct_done"}, ct_done_seen, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ct_start = 1'b0; src_req = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(xfer_valid == 1'b0, "R1 xfer_valid", int'(xfer_valid), 0);
    chk(src_done == '0, "R1 src_done", int'(src_done), 0);
    chk(ct_done == 1'b0, "R1 ct_done", int'(ct_done), 0);
    mon_en = 1'b1;

    // R9: request with no open turn is ignored
    @(posedge clk); #1 src_req = 4'b0100;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(xfer_valid == 1'b0, "R9 closed-turn request", int'(xfer_valid), 0);
    end
    @(posedge clk); #1 src_req = '0;

    // Turn 1: arrivals 2, then 0, then tie {1,3} at pointer 0 -> 2,0,1,3
    ct_done_seen = 0;
    expect_sweep(2); expect_sweep(0); expect_sweep(1); expect_sweep(3);
    pulse_start();
    src_req = 4'b0100;
    @(posedge clk); #1 src_req = 4'b0101;
    @(posedge clk); #1 src_req = 4'b1111;
    repeat (5) @(posedge clk);
    // R10: mid-turn start is ignored; if honoured, held requests would re-enter
    #1 ct_start = 1'b1;
    @(posedge clk); #1 ct_start = 1'b0;
    finish_turn("T1");

    // Turn 2: four-way tie at pointer 1 with stalling destinations -> 1,2,3,0
    rdy_random = 1'b1;
    ct_done_seen = 0;
    expect_sweep(1); expect_sweep(2); expect_sweep(3); expect_sweep(0);
    pulse_start();
    src_req = 4'b1111;
    finish_turn("T2");

    // Turn 3: R3 pointer moved to 2 -> 2,3,0,1
    ct_done_seen = 0;
    expect_sweep(2); expect_sweep(3); expect_sweep(0); expect_sweep(1);
    pulse_start();
    src_req = 4'b1111;
    finish_turn("T3");

    // Turn 4: single arrival keeps pointer 3, tie {0,2} -> 0 then 2
    rdy_random = 1'b0;
    ct_done_seen = 0;
    expect_sweep(1); expect_sweep(0); expect_sweep(2); expect_sweep(3);
    pulse_start();
    src_req = 4'b0010;
    @(posedge clk); #1 src_req = 4'b0111;
    @(posedge clk); #1 src_req = 4'b1111;
    finish_turn("T4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule